// File: doc/BRIEF.md
# Double-Buffered SPI Master Shift Engine

This block is a full-duplex SPI master built around one shift register, with a one-entry transmit holding register in front of it and a one-entry receive holding register behind it. The processor side, or a DMA engine, drops the next word into the transmit holding register while the current word is still on the wire. When a word finishes, the bits collected from MISO are copied into the receive holding register. If a further word is already waiting, it is loaded straight into the shifter, so a burst runs with no idle clock between words.

The serial clock comes from a programmable divider on the system clock. The wire format is fixed: SCK idles low, MISO is sampled on the rising edge, MOSI changes on the falling edge, and the most significant bit goes first. Each word is 8 or 16 bits. Chip select stays low for a whole burst. Two status flags, transmit-empty and receive-full, can each be gated onto a request line that drives an interrupt or a DMA channel. Two sticky error flags report a lost received word and a write that was ignored.

Top module: `spi_dbuf_master`

## Requirements
- R1: While no word is in flight, `cs_n` is high and `sck` is low. `sck` is never high while `cs_n` is high. After reset, `tx_empty`=1 and `rx_full`=0.
- R2: Each `sck` period moves one bit in each direction, most significant bit first. MOSI is stable while `sck` is high, and MISO is captured on the rising edge of `sck`.
- R3: `wide`=1 selects 16-bit words. `wide`=0 selects 8-bit words, which are sent from `tx_data[7:0]` and returned in `rx_data[7:0]` with `rx_data[15:8]`=0. `wide` is sampled when a word is loaded into the shifter, and a change during the word has no effect on it.
- R4: Each half period of `sck` lasts `clk_div`+1 system clocks. A lone word of N bits keeps `cs_n` low for exactly 2·N·(`clk_div`+1) cycles.
- R5: A write to the transmit holding register while a word is shifting does not alter the word in progress. `tx_empty` is 1 exactly when the holding register is free.
- R6: If the holding register is full when a word ends, the next word starts on the same cycle. A burst of K words of N bits keeps `cs_n` low for exactly K·2·N·(`clk_div`+1) cycles.
- R7: `cs_n` rises only when the shifter has finished and the holding register is empty.
- R8: At the end of each word the received word is copied to `rx_data` and `rx_full` is set. A one-cycle pulse on `rx_rd` clears `rx_full`.
- R9: If a word ends while `rx_full` is set and no read occurs that cycle, `overrun` is set and the new word replaces the old one. `rx_rd` clears `overrun`.
- R10: A write while the holding register is full is dropped and sets `wr_collide`. The dropped word never reaches MOSI. The next accepted write clears `wr_collide`.
- R11: `tx_req` = `tx_req_en` AND `tx_empty`, and `rx_req` = `rx_req_en` AND `rx_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | SCK half period minus one, in system clocks |
| wide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 16 | Word to transmit |
| tx_empty | output | 1 | Transmit holding register free |
| wr_collide | output | 1 | Sticky: a write was dropped because the register was full |
| rx_rd | input | 1 | Read strobe for the receive holding register |
| rx_data | output | 16 | Last received word |
| rx_full | output | 1 | Received word waiting |
| overrun | output | 1 | Sticky: an unread word was overwritten |
| tx_req_en | input | 1 | Enable for the transmit request line |
| rx_req_en | input | 1 | Enable for the receive request line |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench measures how long `cs_n` stays low for a single word and for a three-word burst. A design that let a single idle half period slip into the handoff between words, or that miscounted the divider, would miss the exact cycle counts. It writes a third word while the holding register is full and checks that the word never appears on MOSI; a design that accepted it, or that overwrote the waiting word, would show a MOSI stream that differs from the expected one. It holds back reads to force an overrun and checks that the newer word wins and that the flag clears on read. It also changes `wide` in the middle of a 16-bit word; a design that does not latch the width at load would cut that word short at 8 bits.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  localparam int unsigned WORD_MAX = 16;
  localparam int unsigned WORD_MIN = 8;
  localparam int unsigned BIT_W    = $clog2(WORD_MAX) + 1;
  typedef logic [WORD_MAX-1:0] word_t;
endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] clk_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == clk_div);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_dbuf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  wide,
  input  logic  hold_valid,
  input  word_t hold_data,
  input  logic  miso,
  output logic  take,
  output logic  done,
  output word_t rx_word,
  output logic  active,
  output logic  sck,
  output logic  mosi,
  output logic  cs_n
);
  localparam int unsigned PAD = WORD_MAX - WORD_MIN;

  logic             active_q, active_d;
  logic             sck_q, sck_d;
  logic             wide_q, wide_d;
  word_t            tx_sh_q, tx_sh_d;
  word_t            rx_sh_q, rx_sh_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [BIT_W-1:0] last_bit;
  logic             rise, fall, start_idle;

  assign last_bit   = wide_q ? BIT_W'(WORD_MAX - 1) : BIT_W'(WORD_MIN - 1);
  assign start_idle = !active_q && hold_valid;
  assign rise       = active_q && tick && !sck_q;
  assign fall       = active_q && tick && sck_q;
  assign done       = fall && (bit_q == last_bit);
  assign take       = start_idle || (done && hold_valid);

  always_comb begin
    active_d = active_q;
    sck_d    = sck_q;
    wide_d   = wide_q;
    tx_sh_d  = tx_sh_q;
    rx_sh_d  = rx_sh_q;
    bit_d    = bit_q;
    if (rise) begin
      sck_d   = 1'b1;
      rx_sh_d = {rx_sh_q[WORD_MAX-2:0], miso};
    end
    if (fall) begin
      sck_d = 1'b0;
      if (!done) begin
        tx_sh_d = {tx_sh_q[WORD_MAX-2:0], 1'b0};
        bit_d   = bit_q + 1'b1;
      end else begin
        active_d = 1'b0;
      end
    end
    if (take) begin
      active_d = 1'b1;
      wide_d   = wide;
      bit_d    = '0;
      tx_sh_d  = wide ? hold_data : {hold_data[WORD_MIN-1:0], {PAD{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      wide_q   <= 1'b0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
      bit_q    <= '0;
    end else begin
      active_q <= active_d;
      sck_q    <= sck_d;
      wide_q   <= wide_d;
      tx_sh_q  <= tx_sh_d;
      rx_sh_q  <= rx_sh_d;
      bit_q    <= bit_d;
    end
  end

  assign rx_word = wide_q ? rx_sh_q : {{PAD{1'b0}}, rx_sh_q[WORD_MIN-1:0]};
  assign active  = active_q;
  assign sck     = sck_q;
  assign mosi    = active_q ? tx_sh_q[WORD_MAX-1] : 1'b0;
  assign cs_n    = !active_q;

  // R1
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !sck_q);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> $stable(mosi));
  // R4
  sck_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !tick) |=> $stable(sck_q));
endmodule

// File: rtl/spi_hold_regs.sv
module spi_hold_regs
  import spi_dbuf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tx_wr,
  input  word_t tx_data,
  input  logic  take,
  input  logic  done,
  input  word_t rx_word,
  input  logic  rx_rd,
  output logic  tx_full,
  output word_t hold_data,
  output logic  wr_collide,
  output word_t rx_data,
  output logic  rx_full,
  output logic  overrun
);
  logic  tx_full_q, tx_full_d;
  word_t hold_q, hold_d;
  logic  coll_q, coll_d;
  word_t rx_q, rx_d;
  logic  rx_full_q, rx_full_d;
  logic  ovr_q, ovr_d;

  always_comb begin
    tx_full_d = tx_full_q;
    hold_d    = hold_q;
    coll_d    = coll_q;
    if (take) tx_full_d = 1'b0;
    if (tx_wr) begin
      if (tx_full_q) begin
        coll_d = 1'b1;
      end else begin
        coll_d    = 1'b0;
        tx_full_d = 1'b1;
        hold_d    = tx_data;
      end
    end
  end

  always_comb begin
    rx_d      = rx_q;
    rx_full_d = rx_full_q;
    ovr_d     = ovr_q;
    if (rx_rd) begin
      rx_full_d = 1'b0;
      ovr_d     = 1'b0;
    end
    if (done) begin
      rx_full_d = 1'b1;
      rx_d      = rx_word;
      if (rx_full_q && !rx_rd) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full_q <= 1'b0;
      hold_q    <= '0;
      coll_q    <= 1'b0;
      rx_q      <= '0;
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      tx_full_q <= tx_full_d;
      hold_q    <= hold_d;
      coll_q    <= coll_d;
      rx_q      <= rx_d;
      rx_full_q <= rx_full_d;
      ovr_q     <= ovr_d;
    end
  end

  assign tx_full    = tx_full_q;
  assign hold_data  = hold_q;
  assign wr_collide = coll_q;
  assign rx_data    = rx_q;
  assign rx_full    = rx_full_q;
  assign overrun    = ovr_q;

  // R10
  hold_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full_q) |=> ($stable(hold_q) && coll_q));
  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_full_q && !rx_rd) |=> ovr_q);
  // R8
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !done) |=> !rx_full_q);
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
  import spi_dbuf_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    clk_div,
  input  logic                wide,
  input  logic                tx_wr,
  input  logic [WORD_MAX-1:0] tx_data,
  output logic                tx_empty,
  output logic                wr_collide,
  input  logic                rx_rd,
  output logic [WORD_MAX-1:0] rx_data,
  output logic                rx_full,
  output logic                overrun,
  input  logic                tx_req_en,
  input  logic                rx_req_en,
  output logic                tx_req,
  output logic                rx_req,
  output logic                sck,
  output logic                mosi,
  input  logic                miso,
  output logic                cs_n
);
  logic [1:0] rst_sync_q;
  logic       rst_i;
  logic       tick, take, done, active, tx_full;
  word_t      hold_data, rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  spi_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk     (clk),
    .rst_n   (rst_i),
    .run     (active),
    .clk_div (clk_div),
    .tick    (tick)
  );

  spi_shift_core u_core (
    .clk        (clk),
    .rst_n      (rst_i),
    .tick       (tick),
    .wide       (wide),
    .hold_valid (tx_full),
    .hold_data  (hold_data),
    .miso       (miso),
    .take       (take),
    .done       (done),
    .rx_word    (rx_word),
    .active     (active),
    .sck        (sck),
    .mosi       (mosi),
    .cs_n       (cs_n)
  );

  spi_hold_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_i),
    .tx_wr      (tx_wr),
    .tx_data    (tx_data),
    .take       (take),
    .done       (done),
    .rx_word    (rx_word),
    .rx_rd      (rx_rd),
    .tx_full    (tx_full),
    .hold_data  (hold_data),
    .wr_collide (wr_collide),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .overrun    (overrun)
  );

  assign tx_empty = !tx_full;
  assign tx_req   = tx_req_en && !tx_full;
  assign rx_req   = rx_req_en && rx_full;

  // R7
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(cs_n) |-> $past(!tx_full));
  // R6
  reload_keeps_cs_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (done && tx_full) |=> !cs_n);
endmodule

// File: tb/spi_dbuf_master_bench.sv
module spi_dbuf_master_bench;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [DIV_W-1:0] clk_div;
  logic             wide, tx_wr, rx_rd, miso;
  logic [15:0]      tx_data, rx_data;
  logic             tx_empty, wr_collide, rx_full, overrun;
  logic             tx_req_en, rx_req_en, tx_req, rx_req, sck, mosi, cs_n;

  always #4 clk = ~clk;

  spi_dbuf_master #(.DIV_W(DIV_W)) u_spi_dbuf_master (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .wide(wide),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty), .wr_collide(wr_collide),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .overrun(overrun),
    .tx_req_en(tx_req_en), .rx_req_en(rx_req_en), .tx_req(tx_req), .rx_req(rx_req),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;
  bit wide_b = 0;
  bit auto_rd = 1;
  logic [15:0] exp_mosi[$];
  logic [15:0] exp_rx[$];
  logic [15:0] slv_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] msk(logic [15:0] w);
    return wide_b ? w : {8'h00, w[7:0]};
  endfunction

  function automatic logic [15:0] align(logic [15:0] w);
    return wide_b ? w : {w[7:0], 8'h00};
  endfunction

  // Slave model: MISO from a shift register, MOSI collected and scored.
  logic [15:0] slv_sh = '0;
  logic [15:0] mo_sh  = '0;
  int          bcnt   = 0;
  assign miso = slv_sh[15];

  always @(negedge cs_n) begin
    bcnt = 0;
    if (slv_q.size() > 0) slv_sh = align(slv_q.pop_front());
  end

  always @(posedge sck) begin
    mo_sh = {mo_sh[14:0], mosi};
    bcnt++;
    if (bcnt == (wide_b ? 16 : 8)) begin
      bcnt = 0;
      if (exp_mosi.size() == 0) chk("R2 unexpected MOSI word", {16'h0, mo_sh}, 32'hFFFF_FFFF);
      else chk("R2 MOSI word", {16'h0, msk(mo_sh)}, {16'h0, exp_mosi.pop_front()});
    end
  end

  always @(negedge sck) begin
    #1;
    if (bcnt == 0) begin
      if (!cs_n && slv_q.size() > 0) slv_sh = align(slv_q.pop_front());
    end else begin
      slv_sh = {slv_sh[14:0], 1'b0};
    end
  end

  // Receive monitor: pops expected words as the design reports them.
  always @(negedge clk) begin
    if (!rst_n) rx_rd <= 1'b0;
    else if (auto_rd && rx_full && !rx_rd) begin
      if (exp_rx.size() == 0) chk("R8 unexpected rx word", {16'h0, rx_data}, 32'hFFFF_FFFF);
      else chk("R8 rx word", {16'h0, rx_data}, {16'h0, exp_rx.pop_front()});
      rx_rd <= 1'b1;
    end else rx_rd <= 1'b0;
  end

  // Chip-select window timing.
  int cyc = 0, t_fall = 0, last_dur = 0, cs_rises = 0;
  logic prev_cs = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (prev_cs === 1'b1 && cs_n === 1'b0) t_fall = cyc;
    if (prev_cs === 1'b0 && cs_n === 1'b1) begin
      last_dur = cyc - t_fall;
      cs_rises++;
    end
    prev_cs = cs_n;
  end

  task automatic send(logic [15:0] w, logic [15:0] s);
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    exp_mosi.push_back(msk(w));
    exp_rx.push_back(msk(s));
    slv_q.push_back(s);
    tx_wr   = 1'b1;
    tx_data = w;
    @(negedge clk);
    tx_wr   = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (!(cs_n && tx_empty)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; clk_div = '0; wide = 1'b0; tx_wr = 1'b0; tx_data = '0;
    tx_req_en = 1'b0; rx_req_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset cs_n", cs_n, 1);
    chk("R1 reset sck", sck, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle tx_empty", tx_empty, 1);
    chk("R1 idle rx_full", rx_full, 0);
    chk("R11 tx_req gated off", tx_req, 0);
    tx_req_en = 1'b1;
    @(negedge clk);
    chk("R11 tx_req when empty", tx_req, 1);

    // R4 / R3: lone 8-bit word, divider 1
    wide_b = 0; wide = 0; clk_div = 8'd1;
    send(16'hBEA5, 16'h7E3C);
    wait_idle();
    chk("R4 8-bit window div1", last_dur, 2*8*2);
    chk("R1 idle sck low", sck, 0);

    // R4: lone 8-bit word, divider 3
    clk_div = 8'd3;
    send(16'h0081, 16'h00C3);
    wait_idle();
    chk("R4 8-bit window div3", last_dur, 2*8*4);

    // R6 / R5 / R7: three 16-bit words back to back, divider 0
    wide_b = 1; wide = 1; clk_div = 8'd0;
    cs_rises = 0;
    send(16'hA55A, 16'h1234);
    send(16'h8001, 16'hFEDC);
    send(16'h3C96, 16'h0F0F);
    wait_idle();
    chk("R6 burst window", last_dur, 3*2*16*1);
    chk("R7 one release per burst", cs_rises, 1);
    chk("R5 all words shifted", exp_mosi.size(), 0);

    // R10: write while full is dropped
    wide_b = 0; wide = 0; clk_div = 8'd3;
    send(16'h0011, 16'h0022);
    send(16'h0033, 16'h0044);
    @(negedge clk);
    chk("R5 tx_empty low when held", tx_empty, 0);
    tx_wr = 1'b1; tx_data = 16'h00EE;
    @(negedge clk);
    tx_wr = 1'b0;
    chk("R10 collision flag", wr_collide, 1);
    wait_idle();
    chk("R10 dropped word not sent", exp_mosi.size(), 0);
    send(16'h0055, 16'h0066);
    chk("R10 flag cleared by write", wr_collide, 0);
    wait_idle();

    // R9 / R8 / R11: overrun with reads held back
    clk_div = 8'd0; rx_req_en = 1'b1; auto_rd = 0;
    send(16'h00A1, 16'h00B2);
    send(16'h00C3, 16'h00D4);
    wait_idle();
    chk("R8 rx_full set", rx_full, 1);
    chk("R9 overrun set", overrun, 1);
    chk("R9 newer word kept", rx_data, 16'h00D4);
    chk("R11 rx_req", rx_req, 1);
    void'(exp_rx.pop_front());
    auto_rd = 1;
    repeat (4) @(negedge clk);
    chk("R9 overrun cleared by read", overrun, 0);
    chk("R8 rx_full cleared by read", rx_full, 0);
    chk("R11 rx_req drops", rx_req, 0);

    // R3: width latched at word start
    wide_b = 1; wide = 1; clk_div = 8'd1;
    send(16'hC0DE, 16'h5AA5);
    repeat (2) @(negedge clk);
    wide = 0;
    wait_idle();
    chk("R3 width latched window", last_dur, 2*16*2);
    chk("R3 16-bit word completed", exp_rx.size(), 0);

    done_flag = 1;
    report();
  end
endmodule